// File: doc/BRIEF.md
# Rounding Correction Shift Generator

This block serves one operand of a multiplier that works on signed-digit significands. In that multiplier the operand is cut at a rounding position that is only approximate. The position comes from the leading non-zero bit of the most significant digit. A slow signed-sticky flag can move the true position one place lower. When the flag is set, the bit at the true position, written `b`, lies between the cut and the true position and still has to be counted. The rounding digit `r` (−1, 0 or +1) at the true position must also be added. Together they give a correction term `(b + r) × other_operand`.

The block decides the weight and the sign of that term. It produces a one-hot shift select, a mutually exclusive pair of sign selects, and two partial-product vectors for the reduction tree, one positive and one negative. A `b + r` of ±2 is handled as ±1 one position higher, so the sign selects never carry more than a unit magnitude. All outputs are registered with a latency of one cycle.

Top module: `rc_shift_gen`

## Requirements
- R1: While `rst_n` is low, every output is zero.
- R2: Rounding positions are numbered by shift: 4 (bit f), 3 (g), 2 (h), 1 (i), 0 (guard pair). `msd_lead` is one-hot, with bit 3 for the top MSD bit down to bit 0 for the lowest. With `ss_flag` = 0 the position is the lead index plus one, `b` is taken as zero, and `lsd_low` and `grd` have no effect on any output.
- R3: With `ss_flag` = 1 the position is the lead index, and the term is `b + r`. At positions 3, 2 and 1, `b` is `lsd_low[2]`, `lsd_low[1]` and `lsd_low[0]` (g, h, i).
- R4: At position 0 `b` equals −2·`grd[1]` + `grd[0]`. `grd` = 10 never occurs together with a negative `r` there.
- R5: `r` is +1 when `rnd_up[pos]` is set, −1 when `rnd_dn[pos]` is set, and 0 otherwise. The two are never both set at one position.
- R6: When `b + r` is ±2, the selected shift is one higher than the position and the sign select stays a single unit.
- R7: `sh_sel` is one-hot, and bit k means a weight of 2^k. With lead on bit 3 and `ss_flag` = 0 it equals 10000.
- R8: `cor_pos` is 1 when `b + r` > 0 and `cor_neg` is 1 when `b + r` < 0. The two are never both 1.
- R9: `pp_pos − pp_neg` equals `(b + r) × opnd × 2^pos`. At most one of the two vectors is non-zero, and both are zero when `b + r` = 0.
- R10: The outputs reflect the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msd_lead | input | 4 | One-hot leading-bit position in the top digit |
| ss_flag | input | 1 | Signed sticky below the leading bit is negative |
| rnd_up | input | 5 | Per-position rounding value +1 |
| rnd_dn | input | 5 | Per-position rounding value −1 |
| lsd_low | input | 3 | Low bits g, h, i of the least significant digit |
| grd | input | 2 | Guard pair {negative bit, positive bit} |
| opnd | input | W | Chopped other operand |
| sh_sel | output | 5 | One-hot shift select |
| cor_pos | output | 1 | Correction is +1 at the selected shift |
| cor_neg | output | 1 | Correction is −1 at the selected shift |
| pp_pos | output | W+4 | Positive partial-product vector |
| pp_neg | output | W+4 | Negative partial-product vector |

## Verification
The assertions assume that `msd_lead` is one-hot and that `rnd_up` and `rnd_dn` never both mark the same position. They also assume that guard pair 10 never comes with a negative rounding value at position 0. The random stimulus meets these assumptions by construction. The lead is drawn as a single set bit. Each position draws one of three rounding values. The down value at position 0 is cleared whenever the guard pair is 10. Directed vectors cover every guard pair at position 0, and a ±2 sum at an upper position.

// File: rtl/rc_shift_gen.sv
module rc_shift_gen #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [3:0]     msd_lead,
  input  logic           ss_flag,
  input  logic [4:0]     rnd_up,
  input  logic [4:0]     rnd_dn,
  input  logic [2:0]     lsd_low,
  input  logic [1:0]     grd,
  input  logic [W-1:0]   opnd,
  output logic [4:0]     sh_sel,
  output logic           cor_pos,
  output logic           cor_neg,
  output logic [W+3:0]   pp_pos,
  output logic [W+3:0]   pp_neg
);
  localparam int PW = W + 4;

  logic [4:0]        loc_oh, sh_oh;
  logic              r_up, r_dn, big;
  logic signed [2:0] b_val, r_val, sum;
  logic [PW-1:0]     shv;
  logic              armed;

  assign loc_oh = ss_flag ? {1'b0, msd_lead} : {msd_lead, 1'b0};
  assign r_up   = |(loc_oh & rnd_up);
  assign r_dn   = |(loc_oh & rnd_dn);
  assign r_val  = r_up ? 3'sb001 : (r_dn ? 3'sb111 : 3'sb000);

  always_comb begin
    b_val = 3'sb000;
    if (ss_flag) begin
      unique case (1'b1)
        msd_lead[3]: b_val = {2'b00, lsd_low[2]};
        msd_lead[2]: b_val = {2'b00, lsd_low[1]};
        msd_lead[1]: b_val = {2'b00, lsd_low[0]};
        msd_lead[0]: b_val = {grd[1], grd[1], grd[0]};
        default:     b_val = 3'sb000;
      endcase
    end
  end

  assign sum   = b_val + r_val;
  assign big   = (sum == 3'sb010) || (sum == 3'sb110);
  assign sh_oh = big ? {loc_oh[3:0], 1'b0} : loc_oh;

  always_comb begin
    shv = '0;
    for (int k = 0; k < 5; k++)
      if (sh_oh[k]) shv = shv | (PW'(opnd) << k);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_sel  <= '0;
      cor_pos <= 1'b0;
      cor_neg <= 1'b0;
      pp_pos  <= '0;
      pp_neg  <= '0;
      armed   <= 1'b0;
    end else begin
      sh_sel  <= sh_oh;
      cor_pos <= !sum[2] && (sum != 3'sb000);
      cor_neg <= sum[2];
      pp_pos  <= (!sum[2] && (sum != 3'sb000)) ? shv : '0;
      pp_neg  <= sum[2] ? shv : '0;
      armed   <= 1'b1;
    end
  end

  // R8
  sign_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cor_pos && cor_neg));

  // R9
  pp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cor_pos || cor_neg) |-> (pp_pos == '0 && pp_neg == '0));

  // R7
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past($countones(msd_lead) == 1) |-> $countones(sh_sel) == 1);

  // R7
  lead_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(!ss_flag && msd_lead == 4'b1000) |-> sh_sel == 5'b10000);

  // R6
  g0_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(ss_flag && msd_lead == 4'b0001 && grd == 2'b01 && rnd_up[0])
    |-> (sh_sel == 5'b00010 && cor_pos));

  // R2
  nom_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(!ss_flag && rnd_up == 5'b0 && rnd_dn == 5'b0)
    |-> (!cor_pos && !cor_neg));
endmodule

// File: tb/rc_shift_gen_tb.sv
`timescale 1ns/1ps
module rc_shift_gen_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   msd_lead = 4'b1000;
  logic         ss_flag = 1'b0;
  logic [4:0]   rnd_up = '0, rnd_dn = '0;
  logic [2:0]   lsd_low = '0;
  logic [1:0]   grd = '0;
  logic [W-1:0] opnd = '0;
  logic [4:0]   sh_sel;
  logic         cor_pos, cor_neg;
  logic [W+3:0] pp_pos, pp_neg;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  rc_shift_gen #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .msd_lead(msd_lead), .ss_flag(ss_flag),
    .rnd_up(rnd_up), .rnd_dn(rnd_dn), .lsd_low(lsd_low), .grd(grd),
    .opnd(opnd), .sh_sel(sh_sel), .cor_pos(cor_pos), .cor_neg(cor_neg),
    .pp_pos(pp_pos), .pp_neg(pp_neg));

  function automatic int lead_idx(input logic [3:0] l);
    for (int i = 0; i < 4; i++) if (l[i]) return i;
    return 0;
  endfunction

  function automatic int exp_pos();
    return lead_idx(msd_lead) + (ss_flag ? 0 : 1);
  endfunction

  function automatic int exp_sum();
    int p, r, b;
    p = exp_pos();
    r = rnd_up[p] ? 1 : (rnd_dn[p] ? -1 : 0);
    b = 0;
    if (ss_flag) begin
      case (p)
        3: b = int'(lsd_low[2]);
        2: b = int'(lsd_low[1]);
        1: b = int'(lsd_low[0]);
        default: b = -2 * int'(grd[1]) + int'(grd[0]);
      endcase
    end
    return b + r;
  endfunction

  task automatic chk(input string req, input longint act, input longint expv, input string what);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic apply_and_check(input string req);
    int s, p, k;
    longint diff;
    s = exp_sum();
    p = exp_pos();
    k = p + ((s == 2 || s == -2) ? 1 : 0);
    @(negedge clk);
    diff = longint'(pp_pos) - longint'(pp_neg);
    chk(req, diff, longint'(s) * longint'(opnd) * (longint'(1) << p), "pp difference (R9)");
    chk(req, longint'(sh_sel), longint'(1) << k, "shift select (R7)");
    chk(req, longint'({cor_pos, cor_neg}),
        (s > 0) ? 2 : ((s < 0) ? 1 : 0), "sign pair (R8)");
  endtask

  task automatic drive(input logic [3:0] l, input logic s, input logic [4:0] up,
                       input logic [4:0] dn, input logic [2:0] lo, input logic [1:0] g,
                       input logic [W-1:0] x);
    @(negedge clk);
    msd_lead = l; ss_flag = s; rnd_up = up; rnd_dn = dn;
    lsd_low = lo; grd = g; opnd = x;
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    drive(4'b1000, 1'b0, 5'b10000, 5'b0, 3'b111, 2'b01, 16'h1234);
    @(negedge clk);
    // R1 reset state
    chk("R1", longint'({sh_sel, cor_pos, cor_neg}), 0, "selects in reset");
    chk("R1", longint'(pp_pos) + longint'(pp_neg), 0, "vectors in reset");
    rst_n = 1'b1;

    // R7 lead top, ss clear -> shift 4 (R10: one cycle latency)
    drive(4'b1000, 1'b0, 5'b10000, 5'b0, 3'b000, 2'b00, 16'h0101);
    apply_and_check("R7/R10");
    // R2 low bits ignored with ss clear
    drive(4'b0001, 1'b0, 5'b0, 5'b00010, 3'b111, 2'b11, 16'h00ff);
    apply_and_check("R2");
    drive(4'b0001, 1'b0, 5'b0, 5'b00010, 3'b000, 2'b10, 16'h00ff);
    apply_and_check("R2");
    // R3 upper position with b=1,r=1 -> R6 carry
    drive(4'b1000, 1'b1, 5'b01000, 5'b0, 3'b100, 2'b00, 16'h0033);
    apply_and_check("R3/R6");
    // R3 b=1, r=-1 -> zero
    drive(4'b0100, 1'b1, 5'b0, 5'b00100, 3'b010, 2'b00, 16'h0033);
    apply_and_check("R3/R5");
    // R4 guard pair cases at position 0
    drive(4'b0001, 1'b1, 5'b00001, 5'b0, 3'b000, 2'b01, 16'hbeef);
    apply_and_check("R4/R6 pair 01 r=+1");
    drive(4'b0001, 1'b1, 5'b0, 5'b00001, 3'b000, 2'b11, 16'hbeef);
    apply_and_check("R4/R6 pair 11 r=-1");
    drive(4'b0001, 1'b1, 5'b0, 5'b0, 3'b000, 2'b10, 16'hbeef);
    apply_and_check("R4/R6 pair 10 r=0");
    drive(4'b0001, 1'b1, 5'b00001, 5'b0, 3'b000, 2'b10, 16'hbeef);
    apply_and_check("R4 pair 10 r=+1");
    drive(4'b0001, 1'b1, 5'b00001, 5'b0, 3'b000, 2'b11, 16'hffff);
    apply_and_check("R4/R9 pair 11 r=+1 zero");
    drive(4'b0001, 1'b1, 5'b0, 5'b0, 3'b000, 2'b00, 16'hffff);
    apply_and_check("R4 pair 00");

    for (int n = 0; n < 400; n++) begin
      logic [4:0] up, dn;
      logic [1:0] g;
      up = '0; dn = '0;
      for (int j = 0; j < 5; j++) begin
        int v;
        v = int'($urandom_range(2));
        if (v == 1) up[j] = 1'b1;
        if (v == 2) dn[j] = 1'b1;
      end
      g = 2'($urandom);
      if (g == 2'b10) dn[0] = 1'b0;
      drive(4'b0001 << $urandom_range(3), 1'($urandom), up, dn,
            3'($urandom), g, 16'($urandom));
      apply_and_check("R3/R5/R8/R9 random");
    end

    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", longint'({sh_sel, cor_pos, cor_neg}), 0, "selects after reset");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule